// File: doc/BRIEF.md
# SMBus Host Transaction Controller

This block is a register-programmed SMBus master that runs one transaction at a time. Software loads a target register (7-bit device address plus a direction flag), a command register, a data register and a bit-rate register, then writes the control register with a protocol mode and the start bit. The controller then runs one of four protocols on the bus: receive byte, send byte, read byte-data or write byte-data.

The bus pins are open-drain. For each line the block drives an output-enable (1 pulls the line low) and reads the line back through an input. A received byte lands in the data register. The outcome is reported through sticky status bits that software clears by writing ones to them. Success sets only the done bit. A missing acknowledge or an illegal mode sets the device-error bit. A bus collision sets the collision bit. Any transaction that was cut short also sets the failed bit.

Each bit time has four equal phases whose length comes from the rate register. If another device holds SCL low after the controller releases it, the phase is extended until the line reads high.

Top module: `smb_host`

## Requirements
- R1: After reset the status, control, target, command and data registers read 0, the rate register reads 9, and both output-enables are 0. Whenever the controller is not busy, both output-enables are 0.
- R2: The first byte sent is the target register with bit 0 replaced by the direction of that bus phase. For read byte-data this is write (0) first and read (1) after the repeated START.
- R3: Send byte (mode 3'b001, target bit 0 = 0) puts the address byte and then the data register byte on the bus, and ends with one STOP.
- R4: Receive byte (mode 3'b001, target bit 0 = 1) sends only the address byte. It then reads one byte, answers it with a NACK and stores it in the data register.
- R5: Write byte-data (mode 3'b010, target bit 0 = 0) sends the address byte, the command register byte and the data register byte, in that order.
- R6: Read byte-data (mode 3'b010, target bit 0 = 1) sends the address with write and then the command byte. It then issues a repeated START, sends the address with read, and stores the returned byte in the data register.
- R7: A completed transaction leaves status = 8'h02: done at bit 1, with every other bit 0.
- R8: A NACK on the address byte or on any written byte ends the transaction with a STOP. It sets device-error (bit 2) and failed (bit 4) and does not set done.
- R9: Writing the start bit (control bit 6) with mode field control[4:2] outside {3'b001, 3'b010} sets device-error (bit 2) only. Busy never sets and the bus is not touched.
- R10: Status bits 4:1 are sticky. Writing 1 to a bit position at register offset 0 clears that bit, and writing 0 leaves it unchanged. Bits 7:5 read 0.
- R11: Status bit 0 (busy) reads 1 from the cycle after a valid start until the STOP completes. While busy is set, writes to the control, target, command, data and rate registers are ignored.
- R12: If the controller sends a 1 but reads the data line back as 0, it aborts at once. It releases both lines and sets collision (bit 3) and failed (bit 4).
- R13: Every SCL high period lasts 2*(rate+1) clock cycles.

Register offsets are: status 0, control 1, target 2, command 3, data 4, rate 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the register at reg_addr (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |

## Verification
A bus-level target model acknowledges one address and logs every byte, START and STOP it sees, so each of the four protocols is told apart by its byte order, by its direction bits and by whether a repeated START appears. Runs to an absent address, with illegal mode codes and with the data line held low separate the device-error, illegal-mode and collision outcomes, because each leaves a different status pattern and a different bus trace. Repeated start and register writes issued mid-transaction show that the lock-out holds. SCL high times are measured at two rate settings.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;
  typedef enum logic [1:0] {BOP_START, BOP_STOP, BOP_BIT} bop_t;
  typedef enum logic [1:0] {SK_START, SK_TX, SK_RX, SK_STOP} skind_t;
  typedef enum logic [1:0] {SB_ADDR_W, SB_ADDR_R, SB_CMD, SB_DATA} ssel_t;
  typedef struct packed { skind_t kind; ssel_t sel; } step_t;

  localparam logic [2:0] MODE_BYTE  = 3'b001;
  localparam logic [2:0] MODE_BDATA = 3'b010;
  localparam logic [2:0] RA_STATUS = 3'd0, RA_CTRL = 3'd1, RA_TARGET = 3'd2,
                         RA_CMD = 3'd3, RA_DATA = 3'd4, RA_RATE = 3'd5;
  localparam int CTRL_GO = 6;

  // Step list per protocol; idx counts completed steps.
  function automatic step_t plan_step(input logic bdata, input logic rd, input logic [2:0] idx);
    step_t s;
    s.kind = SK_STOP;
    s.sel  = SB_DATA;
    case (idx)
      3'd0: s.kind = SK_START;
      3'd1: begin
        s.kind = SK_TX;
        s.sel  = (rd && !bdata) ? SB_ADDR_R : SB_ADDR_W;
      end
      3'd2: begin
        if (!bdata) s.kind = rd ? SK_RX : SK_TX;
        else begin s.kind = SK_TX; s.sel = SB_CMD; end
      end
      3'd3: if (bdata) s.kind = rd ? SK_START : SK_TX;
      3'd4: if (bdata && rd) begin s.kind = SK_TX; s.sel = SB_ADDR_R; end
      3'd5: if (bdata && rd) s.kind = SK_RX;
      default: s.kind = SK_STOP;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/smb_tick.sv
`timescale 1ns/1ps
module smb_tick #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (cnt == rate) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == rate);
endmodule

// File: rtl/smb_bitphy.sv
`timescale 1ns/1ps
module smb_bitphy import smb_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  bop_t op,
  input  logic wbit,
  input  logic rel,
  input  logic tick,
  input  logic scl_in,
  input  logic sda_in,
  output logic active,
  output logic done,
  output logic rbit,
  output logic scl_lvl,
  output logic sda_lvl
);
  bop_t       op_q;
  logic       wb_q;
  logic [1:0] ph;
  logic       rest_scl, rest_sda;
  logic       scl_c, sda_c, step;

  always_comb begin
    scl_c = 1'b1;
    sda_c = 1'b1;
    case (op_q)
      BOP_START: begin scl_c = (ph == 2'd1) || (ph == 2'd2); sda_c = (ph < 2'd2); end
      BOP_STOP:  begin scl_c = (ph != 2'd0); sda_c = (ph >= 2'd2); end
      default:   begin scl_c = (ph == 2'd1) || (ph == 2'd2); sda_c = wb_q; end
    endcase
  end

  // A released SCL that still reads low stretches the phase.
  assign step    = active && tick && !(scl_c && !scl_in);
  assign scl_lvl = active ? scl_c : rest_scl;
  assign sda_lvl = active ? sda_c : rest_sda;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; done <= 1'b0; rbit <= 1'b1; ph <= 2'd0;
      op_q <= BOP_STOP; wb_q <= 1'b1; rest_scl <= 1'b1; rest_sda <= 1'b1;
    end else begin
      done <= 1'b0;
      if (rel) begin rest_scl <= 1'b1; rest_sda <= 1'b1; end
      if (go) begin
        active <= 1'b1; ph <= 2'd0; op_q <= op; wb_q <= wbit;
      end else if (step) begin
        if (ph == 2'd2) rbit <= sda_in;
        if (ph == 2'd3) begin
          active <= 1'b0; done <= 1'b1; rest_scl <= scl_c; rest_sda <= sda_c;
        end
        ph <= ph + 2'd1;
      end
    end
  end
endmodule

// File: rtl/smb_seq.sv
`timescale 1ns/1ps
module smb_seq import smb_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic [2:0] mode,
  input  logic [7:0] target,
  input  logic [7:0] cmd,
  input  logic [7:0] data,
  input  logic       ph_done,
  input  logic       rbit,
  output logic       busy,
  output logic       go,
  output bop_t       op,
  output logic       wbit,
  output logic       rel,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       ev_done,
  output logic       ev_nack,
  output logic       ev_coll
);
  typedef enum logic [2:0] {Q_IDLE, Q_NEXT, Q_WAIT, Q_TX, Q_RX, Q_END, Q_REL} q_t;
  q_t         q;
  logic [2:0] idx;
  logic [3:0] bitn;
  logic [7:0] sh, sel_byte;
  logic       abort;
  step_t      st;

  assign st = plan_step(mode == MODE_BDATA, target[0], idx);

  always_comb begin
    case (st.sel)
      SB_ADDR_W: sel_byte = {target[7:1], 1'b0};
      SB_ADDR_R: sel_byte = {target[7:1], 1'b1};
      SB_CMD:    sel_byte = cmd;
      default:   sel_byte = data;
    endcase
  end

  assign ev_done  = (q == Q_END) && ph_done && !abort;
  assign ev_nack  = (q == Q_TX) && ph_done && (bitn == 4'd8) && rbit;
  assign ev_coll  = (q == Q_TX) && ph_done && (bitn < 4'd8) && sh[7] && !rbit;
  assign rx_valid = (q == Q_RX) && ph_done && (bitn == 4'd8);
  assign rx_byte  = sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= Q_IDLE; idx <= '0; bitn <= '0; sh <= '0; abort <= 1'b0;
      busy <= 1'b0; go <= 1'b0; op <= BOP_STOP; wbit <= 1'b1; rel <= 1'b0;
    end else begin
      go  <= 1'b0;
      rel <= 1'b0;
      case (q)
        Q_IDLE: if (launch) begin busy <= 1'b1; idx <= '0; abort <= 1'b0; q <= Q_NEXT; end
        Q_NEXT: begin
          go   <= 1'b1;
          bitn <= '0;
          case (st.kind)
            SK_START: begin op <= BOP_START; q <= Q_WAIT; end
            SK_STOP:  begin op <= BOP_STOP; q <= Q_END; end
            SK_TX:    begin op <= BOP_BIT; sh <= sel_byte; wbit <= sel_byte[7]; q <= Q_TX; end
            default:  begin op <= BOP_BIT; wbit <= 1'b1; q <= Q_RX; end
          endcase
        end
        Q_WAIT: if (ph_done) begin idx <= idx + 3'd1; q <= Q_NEXT; end
        Q_TX: if (ph_done) begin
          if (ev_coll) begin rel <= 1'b1; q <= Q_REL; end
          else if (bitn == 4'd8) begin
            if (rbit) begin abort <= 1'b1; go <= 1'b1; op <= BOP_STOP; q <= Q_END; end
            else begin idx <= idx + 3'd1; q <= Q_NEXT; end
          end else begin
            sh <= {sh[6:0], 1'b1}; bitn <= bitn + 4'd1; go <= 1'b1; wbit <= sh[6];
          end
        end
        Q_RX: if (ph_done) begin
          if (bitn == 4'd8) begin idx <= idx + 3'd1; q <= Q_NEXT; end
          else begin sh <= {sh[6:0], rbit}; bitn <= bitn + 4'd1; go <= 1'b1; wbit <= 1'b1; end
        end
        Q_END: if (ph_done) begin busy <= 1'b0; q <= Q_IDLE; end
        Q_REL: begin busy <= 1'b0; q <= Q_IDLE; end
        default: q <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smb_host.sv
`timescale 1ns/1ps
module smb_host import smb_pkg::*; #(
  parameter logic [7:0] RATE_INIT = 8'd9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       scl_in,
  input  logic       sda_in
);
  logic [2:0] mode_q;
  logic [7:0] target_q, cmd_q, data_q, rate_q;
  logic [4:1] sts_q, sts_set, sts_clr;
  logic       busy, wr_ok, go_wr, mode_ok, launch, illegal;
  logic       go, rel, wbit, ph_active, ph_done, rbit, tick, scl_lvl, sda_lvl;
  logic       rx_valid, ev_done, ev_nack, ev_coll;
  logic [7:0] rx_byte;
  bop_t       ph_op;

  assign wr_ok   = reg_wr && !busy;
  assign go_wr   = wr_ok && (reg_addr == RA_CTRL) && reg_wdata[CTRL_GO];
  assign mode_ok = (reg_wdata[4:2] == MODE_BYTE) || (reg_wdata[4:2] == MODE_BDATA);
  assign launch  = go_wr && mode_ok;
  assign illegal = go_wr && !mode_ok;

  assign sts_set = {ev_nack || ev_coll, ev_coll, ev_nack || illegal, ev_done};
  assign sts_clr = (reg_wr && reg_addr == RA_STATUS) ? reg_wdata[4:1] : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; target_q <= '0; cmd_q <= '0; data_q <= '0;
      rate_q <= RATE_INIT; sts_q <= '0;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      if (wr_ok) begin
        case (reg_addr)
          RA_CTRL:   mode_q   <= reg_wdata[4:2];
          RA_TARGET: target_q <= reg_wdata;
          RA_CMD:    cmd_q    <= reg_wdata;
          RA_DATA:   data_q   <= reg_wdata;
          RA_RATE:   rate_q   <= reg_wdata;
          default: ;
        endcase
      end
      if (rx_valid) data_q <= rx_byte;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_STATUS: reg_rdata = {3'b000, sts_q, busy};
      RA_CTRL:   reg_rdata = {3'b000, mode_q, 2'b00};
      RA_TARGET: reg_rdata = target_q;
      RA_CMD:    reg_rdata = cmd_q;
      RA_DATA:   reg_rdata = data_q;
      RA_RATE:   reg_rdata = rate_q;
      default:   reg_rdata = 8'h00;
    endcase
  end

  smb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .mode(mode_q), .target(target_q),
    .cmd(cmd_q), .data(data_q), .ph_done(ph_done), .rbit(rbit), .busy(busy),
    .go(go), .op(ph_op), .wbit(wbit), .rel(rel), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .ev_done(ev_done), .ev_nack(ev_nack), .ev_coll(ev_coll)
  );

  smb_tick #(.RW(8)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(ph_active), .rate(rate_q), .tick(tick)
  );

  smb_bitphy u_phy (
    .clk(clk), .rst_n(rst_n), .go(go), .op(ph_op), .wbit(wbit), .rel(rel),
    .tick(tick), .scl_in(scl_in), .sda_in(sda_in), .active(ph_active),
    .done(ph_done), .rbit(rbit), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl)
  );

  assign scl_oe = !scl_lvl;
  assign sda_oe = !sda_lvl;
endmodule

// File: rtl/smb_host_chk.sv
`timescale 1ns/1ps
module smb_host_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       busy,
  input logic [4:1] sts,
  input logic [7:0] target,
  input logic       scl_oe,
  input logic       sda_oe
);
  logic ctrl_go, mode_ok;
  assign ctrl_go = reg_wr && (reg_addr == 3'd1) && reg_wdata[6] && !busy;
  assign mode_ok = (reg_wdata[4:2] == 3'b001) || (reg_wdata[4:2] == 3'b010);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_launch_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_go && mode_ok) |=> busy);

  assert_illegal_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_go && !mode_ok) |=> (!busy && sts[2]));

  assert_w1c_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[1] && !busy) |=> !sts[1]);

  assert_target_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 3'd2) |=> $stable(target));

  assert_coll_failed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[3]) |-> sts[4]);
endmodule

bind smb_host smb_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .sts(sts_q), .target(target_q),
  .scl_oe(scl_oe), .sda_oe(sda_oe)
);

// File: tb/smb_host_bench.sv
`timescale 1ns/1ps
module smb_host_bench;
  localparam logic [6:0] SLV = 7'h52;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic scl_oe, sda_oe, scl_w, sda_w;
  logic slv_pull = 1'b0, jam = 1'b0;
  logic [7:0] slv_tx = 8'h00;
  int n_chk = 0, n_err = 0;
  logic done_flag = 1'b0;

  always #10 clk = ~clk;

  assign scl_w = !scl_oe;
  assign sda_w = !(sda_oe || slv_pull || jam);

  smb_host u_smb_host (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .scl_in(scl_w), .sda_in(sda_w)
  );

  // ---- bus target model ----
  logic [7:0] slog [0:15];
  int log_n = 0, start_n = 0, stop_n = 0, cnt = 0;
  logic [7:0] sh = 8'h00;
  logic in_rx = 1'b0, in_tx = 1'b0, first = 1'b0, sel = 1'b0, rdm = 1'b0;

  always @(negedge sda_w) if (scl_w) begin
    start_n++; in_rx = 1'b1; in_tx = 1'b0; cnt = 0; first = 1'b1; slv_pull = 1'b0;
  end
  always @(posedge sda_w) if (scl_w) begin
    stop_n++; in_rx = 1'b0; in_tx = 1'b0; slv_pull = 1'b0;
  end
  always @(posedge scl_w) begin
    if (in_rx && cnt < 8) begin sh = {sh[6:0], sda_w}; cnt++; end
    else if (in_tx) cnt++;
  end
  always @(negedge scl_w) begin
    if (in_rx) begin
      if (cnt == 8) begin
        if (log_n < 16) slog[log_n] = sh;
        log_n++;
        if (first) begin sel = (sh[7:1] == SLV); rdm = sh[0]; end
        slv_pull = sel; cnt = 9;
      end else if (cnt == 9) begin
        slv_pull = 1'b0; cnt = 0;
        if (!sel) in_rx = 1'b0;
        else if (first && rdm) begin in_rx = 1'b0; in_tx = 1'b1; slv_pull = !slv_tx[7]; end
        first = 1'b0;
      end
    end else if (in_tx) begin
      if (cnt < 8) slv_pull = !slv_tx[7-cnt];
      else if (cnt == 8) slv_pull = 1'b0;
      else in_tx = 1'b0;
    end
  end

  // ---- helpers ----
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd0, s);
      if (!s[0]) break;
      @(negedge clk);
    end
  endtask

  task automatic high_time(output int n);
    n = 0;
    while (!scl_oe) @(negedge clk);
    while (scl_oe) @(negedge clk);
    while (!scl_oe) begin n++; @(negedge clk); end
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin rd(3'(a), d); chk("R1 reg after reset", 16'(d), 16'h00); end
    rd(3'd5, d); chk("R1 rate after reset", 16'(d), 16'h09);
    chk("R1 lines released", {14'b0, scl_oe, sda_oe}, 16'h0);
  endtask

  task automatic t_send();
    logic [7:0] d; int n, l0, s0;
    l0 = log_n; s0 = stop_n;
    wr(3'd2, {SLV, 1'b0}); wr(3'd4, 8'h3C); wr(3'd1, 8'h44);
    rd(3'd0, d); chk("R11 busy after launch", 16'(d[0]), 16'h1);
    high_time(n); chk("R13 high time rate 9", 16'(n), 16'd20);
    wait_idle();
    rd(3'd0, d); chk("R7 status after send", 16'(d), 16'h02);
    chk("R3 byte count", 16'(log_n - l0), 16'd2);
    chk("R2 address write", 16'(slog[l0]), 16'hA4);
    chk("R3 data byte", 16'(slog[l0+1]), 16'h3C);
    chk("R3 one stop", 16'(stop_n - s0), 16'd1);
  endtask

  task automatic t_recv();
    logic [7:0] d; int l0;
    wr(3'd0, 8'h1E); rd(3'd0, d); chk("R10 clear all", 16'(d), 16'h00);
    l0 = log_n; slv_tx = 8'hA6;
    wr(3'd2, {SLV, 1'b1}); wr(3'd1, 8'h44); wait_idle();
    chk("R2 address read", 16'(slog[l0]), 16'hA5);
    chk("R4 only address sent", 16'(log_n - l0), 16'd1);
    rd(3'd4, d); chk("R4 byte captured", 16'(d), 16'hA6);
    rd(3'd0, d); chk("R7 status after receive", 16'(d), 16'h02);
  endtask

  task automatic t_wbd();
    logic [7:0] d; int l0;
    wr(3'd0, 8'h02); l0 = log_n;
    wr(3'd2, {SLV, 1'b0}); wr(3'd3, 8'h17); wr(3'd4, 8'hC9); wr(3'd1, 8'h48);
    wait_idle();
    chk("R5 byte count", 16'(log_n - l0), 16'd3);
    chk("R5 order", {slog[l0], slog[l0+1]}, 16'hA417);
    chk("R5 data last", 16'(slog[l0+2]), 16'hC9);
    rd(3'd0, d); chk("R7 status after write byte-data", 16'(d), 16'h02);
  endtask

  task automatic t_rbd();
    logic [7:0] d; int l0, s0, n;
    wr(3'd0, 8'h02); l0 = log_n; s0 = start_n; slv_tx = 8'h5B;
    wr(3'd5, 8'd3); wr(3'd2, {SLV, 1'b1}); wr(3'd3, 8'h2E); wr(3'd1, 8'h48);
    high_time(n); chk("R13 high time rate 3", 16'(n), 16'd8);
    wait_idle();
    chk("R6 bytes", 16'(log_n - l0), 16'd3);
    chk("R6 write then cmd", {slog[l0], slog[l0+1]}, 16'hA42E);
    chk("R6 read address", 16'(slog[l0+2]), 16'hA5);
    chk("R6 repeated start", 16'(start_n - s0), 16'd2);
    rd(3'd4, d); chk("R6 byte captured", 16'(d), 16'h5B);
  endtask

  task automatic t_nack();
    logic [7:0] d; int s0;
    wr(3'd0, 8'h02); s0 = stop_n;
    wr(3'd2, 8'h22); wr(3'd1, 8'h44); wait_idle();
    rd(3'd0, d); chk("R8 nack status", 16'(d), 16'h14);
    chk("R8 stop issued", 16'(stop_n - s0), 16'd1);
    chk("R8 lines released", {14'b0, scl_oe, sda_oe}, 16'h0);
    wr(3'd0, 8'h04); rd(3'd0, d); chk("R10 partial clear", 16'(d), 16'h10);
    wr(3'd0, 8'h10); rd(3'd0, d); chk("R10 clear failed", 16'(d), 16'h00);
  endtask

  task automatic t_illegal();
    logic [7:0] d; int s0;
    s0 = start_n;
    wr(3'd1, 8'h40); rd(3'd0, d); chk("R9 mode 000", 16'(d), 16'h04);
    wr(3'd0, 8'h04);
    wr(3'd1, 8'h5C); rd(3'd0, d); chk("R9 mode 111", 16'(d), 16'h04);
    repeat (50) @(negedge clk);
    chk("R9 bus untouched", 16'(start_n - s0), 16'd0);
    wr(3'd0, 8'h04);
  endtask

  task automatic t_busy();
    logic [7:0] d; int l0, s0;
    wr(3'd5, 8'd9); l0 = log_n; s0 = start_n;
    wr(3'd2, {SLV, 1'b0}); wr(3'd4, 8'h3C); wr(3'd1, 8'h44);
    wr(3'd4, 8'h99); wr(3'd2, 8'h00); wr(3'd1, 8'h48); wr(3'd5, 8'd1);
    wait_idle();
    repeat (60) @(negedge clk);
    rd(3'd4, d); chk("R11 data locked", 16'(d), 16'h3C);
    rd(3'd2, d); chk("R11 target locked", 16'(d), 16'hA4);
    rd(3'd5, d); chk("R11 rate locked", 16'(d), 16'h09);
    chk("R11 single transaction", 16'(start_n - s0), 16'd1);
    chk("R11 bytes", {slog[l0], slog[l0+1]}, 16'hA43C);
    wr(3'd0, 8'h02);
  endtask

  task automatic t_coll();
    logic [7:0] d;
    jam = 1'b1;
    wr(3'd2, {SLV, 1'b0}); wr(3'd1, 8'h44); wait_idle();
    rd(3'd0, d); chk("R12 collision status", 16'(d), 16'h18);
    chk("R12 lines released", {14'b0, scl_oe, sda_oe}, 16'h0);
    jam = 1'b0;
    wr(3'd0, 8'h18);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_send();
    t_recv();
    t_wbd();
    t_rbd();
    t_nack();
    t_illegal();
    t_busy();
    t_coll();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule